// File: doc/BRIEF.md
# Egress VLAN Tag Policy Inserter

This block sits on the transmit side of a switch port. It takes the outgoing frame as a byte-wide stream with valid, ready and last signals. Alongside the stream it receives the VLAN ID and priority the frame was classified to, a 2-bit tagging mode for the port, and the port's native VLAN ID. For each frame it decides whether an 802.1Q tag belongs on the wire. When it does, the block splices four tag bytes in right after the two MAC addresses.

The decision is taken once per frame, on the first accepted byte. While the tag bytes are being emitted, the block pulls its input ready low so that no frame byte is dropped. Bytes outside the insertion window pass straight through with no added latency. Frame check sequence regeneration and priority remapping happen elsewhere.

Top module: `vtag_egress_inserter`

## Requirements
- R1: With mode 0 (`port_mode` = 2'd0) no frame is ever tagged; the output equals the input byte for byte.
- R2: With mode 1 a frame is tagged unless its VLAN ID is 0 or equals `native_vid`.
- R3: With mode 2 a frame is tagged unless its VLAN ID is 0; the native VLAN ID plays no part.
- R4: With mode 3 every frame is tagged, VLAN ID 0 included.
- R5: A tag is the four bytes 8'h81, 8'h00, {pcp[2:0], 1'b0, vid[11:8]}, vid[7:0], in that order. It is emitted after the 12th frame byte, and the original bytes keep their order around it.
- R6: Mode, native VLAN ID, frame VLAN ID and priority are sampled on the accepted first byte of a frame. Changes to them later in the same frame do not alter that frame.
- R7: While tag bytes are emitted `s_tready` is low. Every input byte appears exactly once at the output, and `m_tlast` marks only the final original byte.
- R8: A frame of 12 bytes or fewer leaves unchanged in every mode.
- R9: When `m_tvalid` is high and `m_tready` low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values into the next cycle. This assumes the upstream side keeps a pending byte stable.
- R10: During and right after reset, with no input offered, `m_tvalid` is low and `s_tready` follows `m_tready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_mode | input | 2 | Tagging mode: 0 none, 1 all but native and 0, 2 all but 0, 3 all |
| native_vid | input | 12 | Port native VLAN ID |
| frame_vid | input | 12 | Classified VLAN ID of the current frame |
| frame_pcp | input | 3 | Priority placed in the tag |
| s_tdata | input | 8 | Input frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted when high with valid |
| s_tlast | input | 1 | Input byte is the last of the frame |
| m_tdata | output | 8 | Output byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Output byte is the last of the frame |

## Verification
Two things can fall in the same cycle. The first is a change of mode, native VLAN or frame VLAN arriving just after the first byte is accepted; the second is downstream back-pressure striking during the four tag cycles. The bench flips the classification inputs on the cycle after first-byte acceptance and checks that the frame is shaped by the old values. It also runs tagged frames with `m_tready` toggling and input gaps, and compares the collected output with a model frame built from the requirements. Stalled output bytes are checked to stay stable until they are taken.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

  // Per-port egress tagging policy
  typedef enum logic [1:0] {
    TM_NONE        = 2'd0,
    TM_SKIP_NATIVE = 2'd1,
    TM_SKIP_ZERO   = 2'd2,
    TM_ALL         = 2'd3
  } tag_mode_e;

  // Frame sequencing: header pass, tag emission, body pass
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_TAG  = 2'd1,
    ST_BODY = 2'd2
  } seq_state_e;

endpackage

// File: rtl/vtag_policy.sv
module vtag_policy
  import vtag_pkg::*;
#(
  parameter int VID_W = 12
) (
  input  logic [1:0]       mode_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic [VID_W-1:0] native_i,
  output logic             tag_o
);

  tag_mode_e  mode_e;
  logic       vid_zero;
  logic       vid_native;

  assign mode_e     = tag_mode_e'(mode_i);
  assign vid_zero   = (vid_i == '0);
  assign vid_native = (vid_i == native_i);

  always_comb begin
    case (mode_e)
      TM_NONE:        tag_o = 1'b0;
      TM_SKIP_NATIVE: tag_o = !vid_zero && !vid_native;
      TM_SKIP_ZERO:   tag_o = !vid_zero;
      TM_ALL:         tag_o = 1'b1;
      default:        tag_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/vtag_tag_builder.sv
module vtag_tag_builder #(
  parameter int          VID_W     = 12,
  parameter int          PCP_W     = 3,
  parameter int          BYTE_W    = 8,
  parameter int          TAG_BYTES = 4,
  parameter int          TPID_W    = 16,
  parameter logic [15:0] TPID      = 16'h8100,
  localparam int         IDX_W     = $clog2(TAG_BYTES),
  localparam int         TAG_W     = TAG_BYTES * BYTE_W
) (
  input  logic [VID_W-1:0]  vid_i,
  input  logic [PCP_W-1:0]  pcp_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);

  logic [TAG_W-1:0]  word;
  logic [BYTE_W-1:0] bytes_w [TAG_BYTES];

  // Type value, priority, drop-eligible bit cleared, VLAN ID (network order)
  assign word = {TPID[TPID_W-1:0], pcp_i, 1'b0, vid_i};

  for (genvar k = 0; k < TAG_BYTES; k++) begin : g_byte
    assign bytes_w[k] = word[TAG_W-1-k*BYTE_W -: BYTE_W];
  end

  assign byte_o = bytes_w[idx_i];

  initial begin
    assert (TPID_W + PCP_W + 1 + VID_W == TAG_W)
      else $error("tag field widths do not fill the tag");
  end

endmodule

// File: rtl/vtag_seq.sv
module vtag_seq
  import vtag_pkg::*;
#(
  parameter int  HDR_BYTES = 12,
  parameter int  TAG_BYTES = 4,
  localparam int CNT_W     = $clog2(HDR_BYTES),
  localparam int IDX_W     = $clog2(TAG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_tvalid_i,
  input  logic             s_tlast_i,
  input  logic             m_tready_i,
  input  logic             decide_i,
  output logic             s_ready_o,
  output logic             m_valid_o,
  output logic             first_beat_o,
  output logic             tag_hold_o,
  output seq_state_e       state_o,
  output logic [IDX_W-1:0] tag_idx_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             tag_q, tag_d;
  logic             pass;
  logic             s_hs;
  logic             tag_eff;

  assign pass         = (state_q != ST_TAG);
  assign s_ready_o    = pass && m_tready_i;
  assign m_valid_o    = pass ? s_tvalid_i : 1'b1;
  assign s_hs         = s_tvalid_i && s_ready_o;
  assign first_beat_o = (state_q == ST_HDR) && (cnt_q == '0);
  assign tag_eff      = first_beat_o ? decide_i : tag_q;

  // Next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    tag_d   = tag_q;
    if (first_beat_o && s_hs) begin
      tag_d = decide_i;
    end
    case (state_q)
      ST_HDR: begin
        if (s_hs) begin
          if (s_tlast_i) begin
            cnt_d = '0;
          end else if (cnt_q == CNT_W'(HDR_BYTES - 1)) begin
            cnt_d   = '0;
            idx_d   = '0;
            state_d = tag_eff ? ST_TAG : ST_BODY;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_TAG: begin
        if (m_tready_i) begin
          if (idx_q == IDX_W'(TAG_BYTES - 1)) begin
            idx_d   = '0;
            state_d = ST_BODY;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_BODY: begin
        if (s_hs && s_tlast_i) begin
          state_d = ST_HDR;
        end
      end
      default: state_d = ST_HDR;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      idx_q   <= '0;
      tag_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      tag_q   <= tag_d;
    end
  end

  assign tag_hold_o = tag_q;
  assign state_o    = state_q;
  assign tag_idx_o  = idx_q;

  // Entering tag emission always follows an accepted header byte
  assert_tag_after_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAG && $past(state_q) != ST_TAG) |-> $past(s_hs));

  // Tag emission lasts exactly the tag length of accepted output bytes
  assert_tag_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BODY && $past(state_q) == ST_TAG) |->
      ($past(idx_q) == IDX_W'(TAG_BYTES - 1) && $past(m_tready_i)));

  // A frame ending inside the header returns to a fresh header count
  assert_short_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR && s_hs && s_tlast_i) |=> (state_q == ST_HDR && cnt_q == '0));

endmodule

// File: rtl/vtag_egress_inserter.sv
module vtag_egress_inserter
  import vtag_pkg::*;
#(
  parameter int  VID_W     = 12,
  parameter int  PCP_W     = 3,
  parameter int  BYTE_W    = 8,
  parameter int  HDR_BYTES = 12,
  parameter int  TAG_BYTES = 4,
  localparam int IDX_W     = $clog2(TAG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        port_mode,
  input  logic [VID_W-1:0]  native_vid,
  input  logic [VID_W-1:0]  frame_vid,
  input  logic [PCP_W-1:0]  frame_pcp,
  input  logic [BYTE_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  output logic [BYTE_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              decide;
  logic              first_beat;
  logic              tag_hold;
  seq_state_e        state;
  logic [IDX_W-1:0]  tag_idx;
  logic [VID_W-1:0]  vid_q;
  logic [PCP_W-1:0]  pcp_q;
  logic              cap_en;
  logic [BYTE_W-1:0] tag_byte;
  logic              s_hs;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  vtag_policy #(.VID_W(VID_W)) u_policy (
    .mode_i   (port_mode),
    .vid_i    (frame_vid),
    .native_i (native_vid),
    .tag_o    (decide)
  );

  vtag_seq #(.HDR_BYTES(HDR_BYTES), .TAG_BYTES(TAG_BYTES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .s_tvalid_i   (s_tvalid),
    .s_tlast_i    (s_tlast),
    .m_tready_i   (m_tready),
    .decide_i     (decide),
    .s_ready_o    (s_tready),
    .m_valid_o    (m_tvalid),
    .first_beat_o (first_beat),
    .tag_hold_o   (tag_hold),
    .state_o      (state),
    .tag_idx_o    (tag_idx)
  );

  assign s_hs   = s_tvalid && s_tready;
  assign cap_en = first_beat && s_hs;

  // Tag contents captured with the decision on the first byte
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vid_q <= '0;
      pcp_q <= '0;
    end else if (cap_en) begin
      vid_q <= frame_vid;
      pcp_q <= frame_pcp;
    end
  end

  vtag_tag_builder #(
    .VID_W(VID_W), .PCP_W(PCP_W), .BYTE_W(BYTE_W), .TAG_BYTES(TAG_BYTES)
  ) u_tag (
    .vid_i  (vid_q),
    .pcp_i  (pcp_q),
    .idx_i  (tag_idx),
    .byte_o (tag_byte)
  );

  assign m_tdata = (state == ST_TAG) ? tag_byte : s_tdata;
  assign m_tlast = (state == ST_TAG) ? 1'b0     : s_tlast;

  assert_mode_off_untagged_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_en && port_mode == 2'd0) |=> !tag_hold);

  assert_native_untagged_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_en && port_mode == 2'd1 && frame_vid == native_vid) |=> !tag_hold);

  assert_vid0_untagged_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_en && port_mode != 2'd3 && frame_vid == '0) |=> !tag_hold);

  assert_mode_all_tagged_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_en && port_mode == 2'd3) |=> tag_hold);

  assert_decision_held_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_en |=> $stable(tag_hold));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

endmodule

// File: tb/vtag_egress_inserter_bench.sv
module vtag_egress_inserter_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  port_mode;
  logic [11:0] native_vid;
  logic [11:0] frame_vid;
  logic [2:0]  frame_pcp;
  logic [7:0]  s_tdata;
  logic        s_tvalid;
  logic        s_tready;
  logic        s_tlast;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready;
  logic        m_tlast;

  int checks = 0;
  int fails  = 0;

  vtag_egress_inserter u_vtag_egress_inserter (
    .clk(clk), .rst_n(rst_n), .port_mode(port_mode), .native_vid(native_vid),
    .frame_vid(frame_vid), .frame_pcp(frame_pcp), .s_tdata(s_tdata),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tally(string req, bit ok, string detail);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  function automatic bit want_tag(logic [1:0] mode, logic [11:0] vid, logic [11:0] nat);
    case (mode)
      2'd0:    return 1'b0;
      2'd1:    return (vid != 12'd0) && (vid != nat);
      2'd2:    return (vid != 12'd0);
      default: return 1'b1;
    endcase
  endfunction

  // Drive one frame, collect output, compare with the model frame
  task automatic run_frame(string req, int len, logic [1:0] mode, logic [11:0] vid,
                           logic [2:0] pcp, logic [11:0] nat, bit change_late,
                           int rdy_div, int gap_div, int seed);
    logic [7:0] src[$];
    logic [7:0] exp[$];
    logic [7:0] got[$];
    bit         gl[$];
    int  sent = 0;
    bit  done = 0;
    int  cyc  = 0;
    bit  pend = 0;
    bit  stall_seen = 0;
    logic [7:0] stall_data = 8'h00;
    logic       stall_last = 1'b0;
    int  stall_err = 0;
    int  bad_idx = -1;
    logic [7:0] bad_act = 8'h00;
    logic [7:0] bad_exp = 8'h00;
    int  last_err = 0;

    for (int i = 0; i < len; i++) src.push_back(8'((seed + i * 7) & 8'hff));
    for (int i = 0; i < len; i++) begin
      if (i == 12 && len > 12 && want_tag(mode, vid, nat)) begin
        exp.push_back(8'h81);
        exp.push_back(8'h00);
        exp.push_back({pcp, 1'b0, vid[11:8]});
        exp.push_back(vid[7:0]);
      end
      exp.push_back(src[i]);
    end

    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      m_tready = (rdy_div == 0) ? 1'b1 : ((cyc % rdy_div) != 0);
      if (sent < len && (pend || gap_div == 0 || (cyc % gap_div) != 0)) begin
        s_tvalid = 1'b1;
        s_tdata  = src[sent];
        s_tlast  = (sent == len - 1);
      end else begin
        s_tvalid = 1'b0;
        s_tdata  = 8'h00;
        s_tlast  = 1'b0;
      end
      if (sent == 0 || !change_late) begin
        port_mode  = mode;
        frame_vid  = vid;
        frame_pcp  = pcp;
        native_vid = nat;
      end else begin
        port_mode  = ~mode;
        frame_vid  = vid + 12'd1;
        frame_pcp  = ~pcp;
        native_vid = vid;
      end
      #1;
      if (stall_seen && (m_tvalid !== 1'b1 || m_tdata !== stall_data || m_tlast !== stall_last))
        stall_err++;
      stall_seen = m_tvalid && !m_tready;
      stall_data = m_tdata;
      stall_last = m_tlast;
      if (m_tvalid && m_tready) begin
        got.push_back(m_tdata);
        gl.push_back(m_tlast);
        if (m_tlast) done = 1;
      end
      pend = s_tvalid && !s_tready;
      if (s_tvalid && s_tready) sent++;
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    m_tready = 1'b1;

    for (int i = 0; i < exp.size(); i++) begin
      if (i >= got.size() || got[i] !== exp[i]) begin
        if (bad_idx < 0) begin
          bad_idx = i;
          bad_act = (i < got.size()) ? got[i] : 8'hxx;
          bad_exp = exp[i];
        end
      end
    end
    for (int i = 0; i < gl.size(); i++)
      if (gl[i] !== (i == gl.size() - 1)) last_err++;

    tally(req, done && bad_idx < 0 && got.size() == exp.size(),
          $sformatf("len %0d mode %0d vid %0h: size act %0d exp %0d, byte %0d act %02h exp %02h",
                    len, mode, vid, got.size(), exp.size(), bad_idx, bad_act, bad_exp));
    tally("R7", last_err == 0 && done,
          $sformatf("last marker errors act %0d exp 0", last_err));
    if (rdy_div != 0)
      tally("R9", stall_err == 0, $sformatf("stall changes act %0d exp 0", stall_err));
  endtask

  task automatic test_reset();
    rst_n = 1'b0; s_tvalid = 1'b0; s_tdata = 8'h00; s_tlast = 1'b0; m_tready = 1'b1;
    port_mode = 2'd0; native_vid = 12'd0; frame_vid = 12'd0; frame_pcp = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tally("R10", m_tvalid === 1'b0 && s_tready === 1'b1,
          $sformatf("in reset valid %b ready %b exp 0 1", m_tvalid, s_tready));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tally("R10", m_tvalid === 1'b0 && s_tready === 1'b1,
          $sformatf("after reset valid %b ready %b exp 0 1", m_tvalid, s_tready));
  endtask

  task automatic test_modes();
    run_frame("R1", 40, 2'd0, 12'h005, 3'd2, 12'h005, 0, 0, 0, 1);
    run_frame("R1", 30, 2'd0, 12'h3A7, 3'd7, 12'h001, 0, 0, 0, 2);
    run_frame("R2", 30, 2'd1, 12'h005, 3'd1, 12'h005, 0, 0, 0, 3);
    run_frame("R2", 30, 2'd1, 12'h007, 3'd3, 12'h005, 0, 0, 0, 4);
    run_frame("R2", 30, 2'd1, 12'h000, 3'd3, 12'h005, 0, 0, 0, 5);
    run_frame("R3", 30, 2'd2, 12'h000, 3'd4, 12'h009, 0, 0, 0, 6);
    run_frame("R3", 30, 2'd2, 12'h009, 3'd4, 12'h009, 0, 0, 0, 7);
    run_frame("R4", 30, 2'd3, 12'h000, 3'd0, 12'h000, 0, 0, 0, 8);
    run_frame("R5", 64, 2'd3, 12'hABC, 3'd5, 12'h001, 0, 0, 0, 9);
  endtask

  task automatic test_late_change();
    run_frame("R6", 30, 2'd3, 12'h123, 3'd6, 12'h456, 1, 0, 0, 10);
    run_frame("R6", 30, 2'd0, 12'h123, 3'd6, 12'h456, 1, 0, 0, 11);
    run_frame("R6", 30, 2'd1, 12'h200, 3'd1, 12'h201, 1, 0, 0, 12);
  endtask

  task automatic test_backpressure();
    run_frame("R7", 50, 2'd3, 12'h0F0, 3'd2, 12'h000, 0, 3, 0, 13);
    run_frame("R7", 50, 2'd2, 12'h811, 3'd7, 12'h000, 0, 2, 4, 14);
    run_frame("R7", 25, 2'd1, 12'h044, 3'd1, 12'h045, 0, 0, 3, 15);
  endtask

  task automatic test_short();
    run_frame("R8", 12, 2'd3, 12'h777, 3'd1, 12'h000, 0, 0, 0, 16);
    run_frame("R8", 5,  2'd3, 12'h777, 3'd1, 12'h000, 0, 2, 0, 17);
    run_frame("R8", 1,  2'd3, 12'h777, 3'd1, 12'h000, 0, 0, 0, 18);
    run_frame("R8", 13, 2'd3, 12'h777, 3'd1, 12'h000, 0, 0, 0, 19);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, act timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_modes();
    test_late_change();
    test_backpressure();
    test_short();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule